// File: doc/BRIEF.md
# Adapter Interrupt Indicator Setter

This block turns a message-signalled interrupt write into a pair of atomic bit-set operations in memory, followed by an interrupt to the processor when one is needed. The data word of an incoming MSI carries two values. Its upper bits name a function and its low bits give a vector number. The block uses the function number to look up a route entry. Each entry holds an indicator area base and bit offset, a summary byte base and bit offset, and an interrupt subclass. The block then sets the vector's bit in the indicator area and sets the function's summary bit.

Both bit-sets go through a byte-wide read-modify-write port. The memory side performs the OR atomically and returns the byte as it was before the write. An interrupt word is raised only when the summary byte was entirely clear beforehand. Further MSIs that find the summary already set just add indicator bits, and no extra interrupt is sent. Two faults produce an error event instead of an interrupt: a function number with no valid route, and a memory access that fails.

The block handles one MSI at a time. It signals through a ready output when it can accept the next one.

Top module: `msi_indicator_setter`

## Requirements
- R1: After reset, msi_ready is 1 and mem_req, irq_valid and err_valid are 0.
- R2: An MSI is accepted on a clock edge where msi_valid and msi_ready are both 1. The function number is msi_data shifted right by VEC_W (8) bits, and the vector is msi_data[7:0].
- R3: If the function number is NUM_FUNC or larger, or its rt_valid bit is 0, err_valid pulses for one cycle on the edge after acceptance. In that pulse err_code is 0x01 and err_qual is the vector shifted left by 8 bits. No memory access is made.
- R4: The first access of a routed MSI sets the indicator bit. Its byte address is indicator base + (indicator offset + vector) / 8. Its mask is 0x80 >> ((indicator offset + vector) mod 8), so bit numbering runs from the MSB within each byte.
- R5: The second access sets the summary bit at summary base + summary offset / 8 with mask 0x80 >> (summary offset mod 8). It is issued only after the indicator access has been acknowledged without error.
- R6: If the summary access returns an old byte of 0x00, irq_valid pulses for one cycle on the edge after its acknowledge. irq_word is then 0x8000_0000 OR (subclass << 27).
- R7: If the old summary byte is non-zero, no interrupt is raised.
- R8: An acknowledge with mem_err set ends the sequence. err_valid pulses with err_code 0x02 and err_qual 0. No interrupt follows, and a failed indicator access issues no summary access.
- R9: msi_ready is 0 from acceptance until the sequence ends, and msi_valid during that time has no effect.
- R10: mem_req stays high with mem_addr and mem_mask unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | MSI write present |
| msi_data | input | DATA_W | MSI data word (function number, vector) |
| msi_ready | output | 1 | Block idle, MSI can be accepted |
| rt_valid | input | NUM_FUNC | Route entry valid per function |
| rt_ind_base | input | NUM_FUNC*AW | Indicator area byte base per function |
| rt_ind_off | input | NUM_FUNC*OFF_W | Indicator bit offset per function |
| rt_sum_base | input | NUM_FUNC*AW | Summary area byte base per function |
| rt_sum_off | input | NUM_FUNC*OFF_W | Summary bit offset per function |
| rt_isc | input | NUM_FUNC*3 | Interrupt subclass per function |
| mem_req | output | 1 | Atomic OR request |
| mem_addr | output | AW | Byte address of the request |
| mem_mask | output | 8 | Bits to OR into the byte |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed (valid with mem_ack) |
| mem_old | input | 8 | Byte value before the OR (valid with mem_ack) |
| irq_valid | output | 1 | Interrupt word pulse |
| irq_word | output | 32 | Interrupt word |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 8 | Error event code |
| err_qual | output | 32 | Error event qualifier |

## Verification
The assertions assume that the memory side returns at most one acknowledge per request and only while mem_req is high. They also assume that mem_old and mem_err are meaningful only in the acknowledge cycle. The bench memory model meets this: it drives mem_ack for exactly one cycle after a random delay and then drops it before watching for the next request. Route entries change only while the block is idle, and addresses stay inside the model's byte array. This keeps expected bytes, masks and summary states computable in the bench.

// File: rtl/msi_ind_pkg.sv
`timescale 1ns/1ps
package msi_ind_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IND  = 2'd1,
        ST_SUM  = 2'd2
    } seq_state_e;

    typedef enum logic [7:0] {
        EV_NONE     = 8'h00,
        EV_NO_ROUTE = 8'h01,
        EV_ACCESS   = 8'h02
    } ev_code_e;

    typedef struct packed {
        ev_code_e    code;
        logic [31:0] qual;
    } event_t;

    localparam int          ISC_W            = 3;
    localparam int          ISC_SHIFT        = 27;
    localparam int          QUAL_VEC_SHIFT   = 8;
    localparam logic [31:0] IRQ_ADAPTER_FLAG = 32'h8000_0000;

    // Bit 0 of a byte position is the most significant bit of the byte.
    function automatic logic [7:0] msb_mask(input logic [2:0] pos);
        return 8'h80 >> pos;
    endfunction

    function automatic logic [31:0] make_irq_word(input logic [ISC_W-1:0] isc);
        return IRQ_ADAPTER_FLAG | (32'(isc) << ISC_SHIFT);
    endfunction

endpackage

// File: rtl/msi_route_lookup.sv
`timescale 1ns/1ps
module msi_route_lookup
    import msi_ind_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int AW       = 32,
    parameter int OFF_W    = 16
) (
    input  logic [DATA_W-1:0]         msi_data,
    input  logic [NUM_FUNC-1:0]       rt_valid,
    input  logic [NUM_FUNC*AW-1:0]    rt_ind_base,
    input  logic [NUM_FUNC*OFF_W-1:0] rt_ind_off,
    input  logic [NUM_FUNC*AW-1:0]    rt_sum_base,
    input  logic [NUM_FUNC*OFF_W-1:0] rt_sum_off,
    input  logic [NUM_FUNC*ISC_W-1:0] rt_isc,
    output logic                      hit,
    output logic [VEC_W-1:0]          vec,
    output logic [AW-1:0]             ind_addr,
    output logic [7:0]                ind_mask,
    output logic [AW-1:0]             sum_addr,
    output logic [7:0]                sum_mask,
    output logic [ISC_W-1:0]          isc
);
    localparam int FID_W = DATA_W - VEC_W;
    localparam int IDX_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

    logic [AW-1:0]    ib_a  [NUM_FUNC];
    logic [OFF_W-1:0] io_a  [NUM_FUNC];
    logic [AW-1:0]    sb_a  [NUM_FUNC];
    logic [OFF_W-1:0] so_a  [NUM_FUNC];
    logic [ISC_W-1:0] isc_a [NUM_FUNC];

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_unpack
        assign ib_a[f]  = rt_ind_base[f*AW +: AW];
        assign io_a[f]  = rt_ind_off[f*OFF_W +: OFF_W];
        assign sb_a[f]  = rt_sum_base[f*AW +: AW];
        assign so_a[f]  = rt_sum_off[f*OFF_W +: OFF_W];
        assign isc_a[f] = rt_isc[f*ISC_W +: ISC_W];
    end

    logic [FID_W-1:0] fid;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic [AW-1:0]    sel_ib, sel_sb;
    logic [OFF_W-1:0] sel_io, sel_so;
    logic [OFF_W:0]   ind_pos;

    assign fid      = msi_data[DATA_W-1:VEC_W];
    assign vec      = msi_data[VEC_W-1:0];
    assign idx      = fid[IDX_W-1:0];
    assign in_range = fid < FID_W'(NUM_FUNC);

    always_comb begin
        hit    = 1'b0;
        sel_ib = '0;
        sel_io = '0;
        sel_sb = '0;
        sel_so = '0;
        isc    = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (in_range && idx == IDX_W'(f)) begin
                hit    = rt_valid[f];
                sel_ib = ib_a[f];
                sel_io = io_a[f];
                sel_sb = sb_a[f];
                sel_so = so_a[f];
                isc    = isc_a[f];
            end
        end
    end

    assign ind_pos  = {1'b0, sel_io} + (OFF_W+1)'(vec);
    assign ind_addr = sel_ib + AW'(ind_pos >> 3);
    assign ind_mask = msb_mask(ind_pos[2:0]);
    assign sum_addr = sel_sb + AW'(sel_so >> 3);
    assign sum_mask = msb_mask(sel_so[2:0]);

endmodule

// File: rtl/msi_rmw_seq.sv
`timescale 1ns/1ps
module msi_rmw_seq
    import msi_ind_pkg::*;
#(
    parameter int AW    = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msi_valid,
    input  logic             hit,
    input  logic [VEC_W-1:0] vec,
    input  logic [AW-1:0]    ind_addr,
    input  logic [7:0]       ind_mask,
    input  logic [AW-1:0]    sum_addr,
    input  logic [7:0]       sum_mask,
    input  logic [ISC_W-1:0] isc,
    output logic             msi_ready,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_mask,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [7:0]       mem_old,
    output logic             irq_valid,
    output logic [31:0]      irq_word,
    output logic             err_valid,
    output event_t           err_ev
);
    seq_state_e       state;
    logic [AW-1:0]    cur_addr, sum_addr_q;
    logic [7:0]       cur_mask, sum_mask_q;
    logic [ISC_W-1:0] isc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            cur_mask   <= '0;
            sum_addr_q <= '0;
            sum_mask_q <= '0;
            isc_q      <= '0;
            irq_valid  <= 1'b0;
            irq_word   <= '0;
            err_valid  <= 1'b0;
            err_ev     <= '{code: EV_NONE, qual: '0};
        end else begin
            irq_valid <= 1'b0;
            err_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (msi_valid) begin
                    if (!hit) begin
                        err_valid <= 1'b1;
                        err_ev    <= '{code: EV_NO_ROUTE,
                                       qual: 32'(vec) << QUAL_VEC_SHIFT};
                    end else begin
                        cur_addr   <= ind_addr;
                        cur_mask   <= ind_mask;
                        sum_addr_q <= sum_addr;
                        sum_mask_q <= sum_mask;
                        isc_q      <= isc;
                        state      <= ST_IND;
                    end
                end
                ST_IND: if (mem_ack) begin
                    if (mem_err) begin
                        err_valid <= 1'b1;
                        err_ev    <= '{code: EV_ACCESS, qual: '0};
                        state     <= ST_IDLE;
                    end else begin
                        cur_addr <= sum_addr_q;
                        cur_mask <= sum_mask_q;
                        state    <= ST_SUM;
                    end
                end
                ST_SUM: if (mem_ack) begin
                    if (mem_err) begin
                        err_valid <= 1'b1;
                        err_ev    <= '{code: EV_ACCESS, qual: '0};
                    end else if (mem_old == 8'h00) begin
                        irq_valid <= 1'b1;
                        irq_word  <= make_irq_word(isc_q);
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign msi_ready = (state == ST_IDLE);
    assign mem_req   = (state == ST_IND) || (state == ST_SUM);
    assign mem_addr  = cur_addr;
    assign mem_mask  = cur_mask;

    // R10: a pending request holds address and mask
    a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_mask)));

    // R6: interrupt only after a clean acknowledge that saw a clear byte
    a_r6_irq_needs_clear: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(mem_ack && !mem_err && mem_old == 8'h00));

    // R6: interrupt is a single-cycle pulse
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_valid |=> !irq_valid);

    // R8: an error event never coincides with an interrupt
    a_r8_err_excludes_irq: assert property (@(posedge clk) disable iff (rst)
        !(irq_valid && err_valid));

    // R8: a failed acknowledge is followed by an access error event
    a_r8_fail_reports: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (err_valid && err_ev.code == EV_ACCESS && !mem_req));

endmodule

// File: rtl/msi_indicator_setter.sv
`timescale 1ns/1ps
module msi_indicator_setter
    import msi_ind_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int AW       = 32,
    parameter int OFF_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      msi_valid,
    input  logic [DATA_W-1:0]         msi_data,
    output logic                      msi_ready,
    input  logic [NUM_FUNC-1:0]       rt_valid,
    input  logic [NUM_FUNC*AW-1:0]    rt_ind_base,
    input  logic [NUM_FUNC*OFF_W-1:0] rt_ind_off,
    input  logic [NUM_FUNC*AW-1:0]    rt_sum_base,
    input  logic [NUM_FUNC*OFF_W-1:0] rt_sum_off,
    input  logic [NUM_FUNC*3-1:0]     rt_isc,
    output logic                      mem_req,
    output logic [AW-1:0]             mem_addr,
    output logic [7:0]                mem_mask,
    input  logic                      mem_ack,
    input  logic                      mem_err,
    input  logic [7:0]                mem_old,
    output logic                      irq_valid,
    output logic [31:0]               irq_word,
    output logic                      err_valid,
    output logic [7:0]                err_code,
    output logic [31:0]               err_qual
);
    logic             hit;
    logic [VEC_W-1:0] vec;
    logic [AW-1:0]    ind_addr, sum_addr;
    logic [7:0]       ind_mask, sum_mask;
    logic [ISC_W-1:0] isc;
    event_t           err_ev;

    msi_route_lookup #(
        .NUM_FUNC(NUM_FUNC), .DATA_W(DATA_W), .VEC_W(VEC_W),
        .AW(AW), .OFF_W(OFF_W)
    ) u_lookup (
        .msi_data   (msi_data),
        .rt_valid   (rt_valid),
        .rt_ind_base(rt_ind_base),
        .rt_ind_off (rt_ind_off),
        .rt_sum_base(rt_sum_base),
        .rt_sum_off (rt_sum_off),
        .rt_isc     (rt_isc),
        .hit        (hit),
        .vec        (vec),
        .ind_addr   (ind_addr),
        .ind_mask   (ind_mask),
        .sum_addr   (sum_addr),
        .sum_mask   (sum_mask),
        .isc        (isc)
    );

    msi_rmw_seq #(.AW(AW), .VEC_W(VEC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .msi_valid(msi_valid),
        .hit      (hit),
        .vec      (vec),
        .ind_addr (ind_addr),
        .ind_mask (ind_mask),
        .sum_addr (sum_addr),
        .sum_mask (sum_mask),
        .isc      (isc),
        .msi_ready(msi_ready),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_mask (mem_mask),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .mem_old  (mem_old),
        .irq_valid(irq_valid),
        .irq_word (irq_word),
        .err_valid(err_valid),
        .err_ev   (err_ev)
    );

    assign err_code = err_ev.code;
    assign err_qual = err_ev.qual;

    // R3: unrouted MSI reports at once and starts no access
    a_r3_unrouted_event: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && msi_ready && !hit) |=>
            (err_valid && err_code == 8'h01 && !mem_req));

    // R9: a busy block never also claims to be ready
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !msi_ready);

endmodule

// File: tb/tb_msi_indicator_setter.sv
`timescale 1ns/1ps
module tb_msi_indicator_setter;
    localparam int NF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           msi_valid = 1'b0;
    logic [31:0]    msi_data  = '0;
    logic           msi_ready;
    logic [NF-1:0]  rt_valid;
    logic [NF*32-1:0] rt_ind_base, rt_sum_base;
    logic [NF*16-1:0] rt_ind_off, rt_sum_off;
    logic [NF*3-1:0]  rt_isc;
    logic           mem_req;
    logic [31:0]    mem_addr;
    logic [7:0]     mem_mask;
    logic           mem_ack = 1'b0;
    logic           mem_err = 1'b0;
    logic [7:0]     mem_old = '0;
    logic           irq_valid, err_valid;
    logic [31:0]    irq_word, err_qual;
    logic [7:0]     err_code;

    // route table held by the bench
    logic [31:0] r_ib [NF];
    logic [31:0] r_sb [NF];
    logic [15:0] r_io [NF];
    logic [15:0] r_so [NF];
    logic [2:0]  r_isc [NF];
    logic        r_val [NF];

    always_comb begin
        for (int f = 0; f < NF; f++) begin
            rt_valid[f]            = r_val[f];
            rt_ind_base[f*32 +: 32] = r_ib[f];
            rt_sum_base[f*32 +: 32] = r_sb[f];
            rt_ind_off[f*16 +: 16]  = r_io[f];
            rt_sum_off[f*16 +: 16]  = r_so[f];
            rt_isc[f*3 +: 3]        = r_isc[f];
        end
    end

    msi_indicator_setter dut (
        .clk(clk), .rst(rst),
        .msi_valid(msi_valid), .msi_data(msi_data), .msi_ready(msi_ready),
        .rt_valid(rt_valid), .rt_ind_base(rt_ind_base), .rt_ind_off(rt_ind_off),
        .rt_sum_base(rt_sum_base), .rt_sum_off(rt_sum_off), .rt_isc(rt_isc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_mask(mem_mask),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_old(mem_old),
        .irq_valid(irq_valid), .irq_word(irq_word),
        .err_valid(err_valid), .err_code(err_code), .err_qual(err_qual)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // byte-array memory model with atomic OR
    logic [7:0]  mem [256];
    logic [31:0] acc_addr [4];
    logic [7:0]  acc_mask [4];
    int          acc_n    = 0;
    int          fail_at  = 0;
    int          lat_min  = 0;
    int          lat_max  = 3;
    int          delay    = 0;
    bit          pend     = 1'b0;
    bit          stab_bad = 1'b0;
    logic [31:0] pend_addr;
    logic [7:0]  pend_mask;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
            pend    = 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend      = 1'b1;
                pend_addr = mem_addr;
                pend_mask = mem_mask;
                delay     = $urandom_range(lat_max, lat_min);
            end else if (mem_addr !== pend_addr || mem_mask !== pend_mask) begin
                stab_bad = 1'b1;
            end
            if (delay == 0) begin
                mem_ack = 1'b1;
                mem_old = mem[mem_addr[7:0]];
                if (acc_n < 4) begin
                    acc_addr[acc_n] = mem_addr;
                    acc_mask[acc_n] = mem_mask;
                end
                acc_n++;
                if (fail_at == acc_n) mem_err = 1'b1;
                else mem[mem_addr[7:0]] = mem[mem_addr[7:0]] | mem_mask;
            end else begin
                delay--;
            end
        end
    end

    // pulse monitor
    int          irq_n = 0, err_n = 0;
    logic [31:0] irq_w, err_q;
    logic [7:0]  err_c;
    always @(negedge clk) begin
        if (irq_valid) begin irq_n++; irq_w = irq_word; end
        if (err_valid) begin err_n++; err_c = err_code; err_q = err_qual; end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic [31:0] e_addr(input logic [31:0] base, input logic [15:0] off,
                                           input logic [7:0] v);
        return base + ((32'(off) + 32'(v)) >> 3);
    endfunction

    function automatic logic [7:0] e_mask(input logic [15:0] off, input logic [7:0] v);
        logic [31:0] p;
        p = 32'(off) + 32'(v);
        return 8'h80 >> p[2:0];
    endfunction

    // one MSI with full result check; fail: 0 none, 1 indicator, 2 summary
    task automatic run_msi(input logic [31:0] data, input int fail, input string tag);
        logic [23:0] fid;
        logic [7:0]  v, sold;
        logic [31:0] ia, sa;
        logic [7:0]  im, sm;
        bit          known, exp_irq;
        int          exp_acc, f;
        fid = data[31:8];
        v   = data[7:0];
        f   = int'(fid[1:0]);
        known = (fid < 24'(NF)) && r_val[f];
        ia = e_addr(r_ib[f], r_io[f], v);
        im = e_mask(r_io[f], v);
        sa = e_addr(r_sb[f], r_so[f], 8'd0);
        sm = e_mask(r_so[f], 8'd0);
        sold = mem[sa[7:0]];
        if (ia[7:0] == sa[7:0] && fail != 1) sold = sold | im;
        exp_irq = known && fail == 0 && sold == 8'h00;
        exp_acc = !known ? 0 : (fail == 1 ? 1 : 2);
        while (!msi_ready) @(negedge clk);
        irq_n = 0; err_n = 0; acc_n = 0; stab_bad = 1'b0;
        fail_at = known ? fail : 0;
        msi_valid = 1'b1;
        msi_data  = data;
        @(negedge clk);
        msi_valid = 1'b0;
        while (!msi_ready) @(negedge clk);
        @(negedge clk);
        chk({tag, " R2 R5 access count"}, 32'(acc_n), 32'(exp_acc));
        if (exp_acc >= 1 && acc_n >= 1) begin
            chk({tag, " R4 ind addr"}, acc_addr[0], ia);
            chk({tag, " R4 ind mask"}, 32'(acc_mask[0]), 32'(im));
        end
        if (exp_acc == 2 && acc_n >= 2) begin
            chk({tag, " R5 sum addr"}, acc_addr[1], sa);
            chk({tag, " R5 sum mask"}, 32'(acc_mask[1]), 32'(sm));
        end
        chk({tag, " R10 req stable"}, 32'(stab_bad), 32'd0);
        chk({tag, " R6 R7 irq count"}, 32'(irq_n), exp_irq ? 32'd1 : 32'd0);
        if (exp_irq && irq_n == 1)
            chk({tag, " R6 irq word"}, irq_w, 32'h8000_0000 | (32'(r_isc[f]) << 27));
        chk({tag, " R3 R8 err count"}, 32'(err_n), (!known || fail != 0) ? 32'd1 : 32'd0);
        if (err_n == 1) begin
            if (!known) begin
                chk({tag, " R3 err code"}, 32'(err_c), 32'h01);
                chk({tag, " R3 err qual"}, err_q, 32'(v) << 8);
            end else begin
                chk({tag, " R8 err code"}, 32'(err_c), 32'h02);
                chk({tag, " R8 err qual"}, err_q, 32'd0);
            end
        end
    endtask

    task automatic set_route(input int f, input bit val, input logic [31:0] ib, input logic [15:0] io,
                             input logic [31:0] sb, input logic [15:0] so, input logic [2:0] i);
        r_val[f] = val; r_ib[f] = ib; r_io[f] = io; r_sb[f] = sb; r_so[f] = so; r_isc[f] = i;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        set_route(0, 1'b1, 32'd16, 16'd0,  32'd200, 16'd0,  3'd5);
        set_route(1, 1'b1, 32'd40, 16'd7,  32'd200, 16'd9,  3'd2);
        set_route(2, 1'b0, 32'd60, 16'd0,  32'd210, 16'd3,  3'd1);
        set_route(3, 1'b1, 32'd80, 16'd20, 32'd220, 16'd15, 3'd7);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(msi_ready), 32'd1);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 irq_valid", 32'(irq_valid), 32'd0);
        chk("R1 err_valid", 32'(err_valid), 32'd0);

        // directed: first MSI to a clear summary raises interrupt (R6)
        run_msi({24'd0, 8'd3}, 0, "first");
        chk("R4 indicator bit set", 32'(mem[16]), 32'h10);
        // same function again: summary already set, no interrupt (R7)
        run_msi({24'd0, 8'd9}, 0, "coalesce");
        chk("R4 indicator byte 2", 32'(mem[17]), 32'h40);
        // offset + vector crosses a byte edge (R4)
        run_msi({24'd1, 8'd1}, 0, "cross");
        // unknown function number and invalid route (R3)
        run_msi({24'd4, 8'd17}, 0, "fid_range");
        run_msi({24'd2, 8'd5}, 0, "no_route");
        run_msi({24'hFFFFFF, 8'hAB}, 0, "fid_max");
        // access faults (R8)
        mem[220 + 1] = 8'h00;
        run_msi({24'd3, 8'd2}, 1, "ind_fail");
        run_msi({24'd3, 8'd2}, 2, "sum_fail");
        run_msi({24'd3, 8'd4}, 0, "after_fail");

        // busy: msi_valid while not ready is ignored (R9)
        begin
            lat_min = 3; lat_max = 3;
            mem[200] = 8'h00;
            irq_n = 0; err_n = 0; acc_n = 0; fail_at = 0;
            msi_valid = 1'b1; msi_data = {24'd0, 8'd1};
            @(negedge clk);
            msi_data = {24'd3, 8'd6};
            while (!msi_ready) begin
                chk("R9 ready low while busy", 32'(msi_ready), 32'd0);
                @(negedge clk);
            end
            msi_valid = 1'b0;
            @(negedge clk);
            chk("R9 only one sequence", 32'(acc_n), 32'd2);
            chk("R9 first access is accepted MSI", acc_addr[0], e_addr(32'd16, 16'd0, 8'd1));
            chk("R9 one irq", 32'(irq_n), 32'd1);
            lat_min = 0; lat_max = 3;
        end

        // constrained random
        for (int it = 0; it < 400; it++) begin
            int          rf, fl;
            logic [23:0] fid;
            logic [7:0]  v;
            if (it % 25 == 0) begin
                for (int f = 0; f < NF; f++)
                    set_route(f, ($urandom_range(3, 0) != 0),
                              32'($urandom_range(127, 0)), 16'($urandom_range(255, 0)),
                              32'($urandom_range(127, 0)), 16'($urandom_range(255, 0)),
                              3'($urandom_range(7, 0)));
                for (int a = 0; a < 256; a++) mem[a] = 8'h00;
            end
            rf  = $urandom_range(5, 0);
            fid = 24'(rf);
            v   = 8'($urandom_range(31, 0));
            if (rf < NF && $urandom_range(1, 0) == 1) begin
                logic [31:0] sa;
                sa = e_addr(r_sb[rf], r_so[rf], 8'd0);
                mem[sa[7:0]] = 8'h00;
            end
            fl = $urandom_range(9, 0);
            fl = (fl == 8) ? 1 : (fl == 9) ? 2 : 0;
            run_msi({fid, v}, fl, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule